// File: doc/BRIEF.md
# Polyphase FIR Channelizer Front End

This block is the filtering half of a streaming subband splitter for one antenna's complex sample stream. Each accepted complex sample (4-bit signed real, 4-bit signed imaginary) is routed to one of 1024 polyphase branches in strict rotation. Each branch is a 5-tap FIR whose sample history lives in a branch-indexed memory. Every tap is weighted by its own signed 8-bit coefficient, held in a loadable coefficient store. The block emits one filtered complex sample per accepted input, tagged with its branch index, in the order a following 1024-point radix-2 FFT expects.

Coefficients are written through a small load port while no samples are flowing. The stream may pause for any number of cycles. Idle cycles neither advance the branch rotation nor disturb any branch's history.

Top module: `pfb_channelizer_front`

## Requirements
- R1: While reset is held, and until the first sample has passed through the pipeline, out_valid is 0 and out_re and out_im are 0.
- R2: The first sample accepted after reset goes to branch 0. Each later accepted sample goes to the next branch, modulo 1024. out_branch carries the branch of the sample that produced the output.
- R3: For the n-th sample x_k[n] sent to branch k, out_re = sum over j=0..4 of c[j][k]*Re(x_k[n-j]), and likewise out_im from the imaginary parts. Tap j=0 is the newest sample. All values are signed two's complement, and the outputs are 15 bits wide.
- R4: Branch history is zero after reset. In the first four outputs of each branch, the taps that reach back before reset contribute nothing.
- R5: out_valid is high exactly two clock cycles after a cycle in which in_valid is high, and never otherwise. Outputs keep the input order.
- R6: The outputs never overflow. With every tap at -8 and every coefficient at -128, both outputs are exactly +5120.
- R7: A cycle with coef_we high and in_valid low writes coef_val into c[coef_tap][coef_branch]. coef_tap ranges from 0 (newest) to 4. The new value is used for every later sample of that branch.
- R8: A coefficient write presented in a cycle where in_valid is high is dropped, and the stored coefficient keeps its old value.
- R9: Cycles with in_valid low leave the branch rotation and all branch histories unchanged, whatever their number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | An input sample is present this cycle |
| in_re | input | 4 | Real part of the input sample, signed |
| in_im | input | 4 | Imaginary part of the input sample, signed |
| coef_we | input | 1 | Coefficient write strobe, honoured only while in_valid is low |
| coef_tap | input | 3 | Tap number of the coefficient write, 0 to 4 |
| coef_branch | input | 10 | Branch number of the coefficient write |
| coef_val | input | 8 | Signed coefficient value |
| out_valid | output | 1 | A filtered sample is present this cycle |
| out_re | output | 15 | Real part of the filtered sample, signed |
| out_im | output | 15 | Imaginary part of the filtered sample, signed |
| out_branch | output | 10 | Branch the filtered sample belongs to |

## Verification
On every cycle the assertions check the two-cycle valid latency, the quiet outputs straight after reset, the strict rotation of out_branch, and the magnitude bound that rules out overflow. Only the bench scenarios can show that the arithmetic values are right. That covers the zero-filled taps during the first passes through each branch, the effect of a coefficient reload, the dropped write while the stream is active, and intact history across long idle gaps. The bench checks these by comparing each output with a model that keeps its own history for every branch.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  // Bits needed to sum n products of width pw without overflow.
  function automatic int sum_width(input int pw, input int n);
    return pw + $clog2(n);
  endfunction

endpackage

// File: rtl/pfb_rst_sync.sv
module pfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_q_n = stg_q[1];
endmodule

// File: rtl/pfb_hist_ram.sv
module pfb_hist_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [WIDTH-1:0]         rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/pfb_coef_bank.sv
module pfb_coef_bank #(
  parameter int NBR  = 1024,
  parameter int NTAP = 5,
  parameter int CW   = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [$clog2(NTAP)-1:0] wr_tap,
  input  logic [$clog2(NBR)-1:0]  wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    rd_en,
  input  logic [$clog2(NBR)-1:0]  rd_addr,
  output logic [NTAP*CW-1:0]      rd_data
);
  localparam int TW = $clog2(NTAP);

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    logic [CW-1:0] mem [NBR];
    logic [CW-1:0] rq;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_tap == TW'(t))) mem[wr_addr] <= wr_data;
      if (rd_en) rq <= mem[rd_addr];
    end

    assign rd_data[t*CW +: CW] = rq;
  end
endmodule

// File: rtl/pfb_mac.sv
module pfb_mac #(
  parameter int NTAP = 5,
  parameter int DW   = 4,
  parameter int CW   = 8,
  parameter int AW   = 15
) (
  input  logic [NTAP*DW-1:0] x_flat,
  input  logic [NTAP*CW-1:0] c_flat,
  output logic [AW-1:0]      sum
);
  localparam int PW = DW + CW;

  logic signed [DW-1:0] xs;
  logic signed [CW-1:0] cs;
  logic signed [PW-1:0] prod;
  logic        [AW-1:0] acc;

  always_comb begin
    acc = '0;
    xs = '0;
    cs = '0;
    prod = '0;
    for (int j = 0; j < NTAP; j++) begin
      xs = x_flat[j*DW +: DW];
      cs = c_flat[j*CW +: CW];
      prod = xs * cs;
      acc = acc + {{(AW-PW){prod[PW-1]}}, prod};
    end
    sum = acc;
  end
endmodule

// File: rtl/pfb_channelizer_front.sv
module pfb_channelizer_front #(
  parameter int NBR  = 1024,
  parameter int NTAP = 5,
  parameter int DW   = 4,
  parameter int CW   = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [DW-1:0]                    in_re,
  input  logic [DW-1:0]                    in_im,
  input  logic                             coef_we,
  input  logic [$clog2(NTAP)-1:0]          coef_tap,
  input  logic [$clog2(NBR)-1:0]           coef_branch,
  input  logic [CW-1:0]                    coef_val,
  output logic                             out_valid,
  output logic [DW+CW+$clog2(NTAP)-1:0]    out_re,
  output logic [DW+CW+$clog2(NTAP)-1:0]    out_im,
  output logic [$clog2(NBR)-1:0]           out_branch
);
  localparam int BW = $clog2(NBR);
  localparam int FW = $clog2(NTAP);
  localparam int AW = pfb_pkg::sum_width(DW + CW, NTAP);
  localparam int SW = 2 * DW;
  localparam int HW = (NTAP - 1) * SW;

  logic rst_q_n;

  pfb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  // Branch rotation and fill count (number of complete passes, saturating).
  logic [BW-1:0] br_q, br_d;
  logic [FW-1:0] fill_q, fill_d;

  always_comb begin
    br_d   = br_q;
    fill_d = fill_q;
    if (in_valid) begin
      if (br_q == BW'(NBR - 1)) begin
        br_d = '0;
        if (fill_q != FW'(NTAP - 1)) fill_d = fill_q + 1'b1;
      end else begin
        br_d = br_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      br_q   <= '0;
      fill_q <= '0;
    end else if (in_valid) begin
      br_q   <= br_d;
      fill_q <= fill_d;
    end
  end

  // Stage 1: sample registered alongside synchronous memory reads.
  logic          s1_v;
  logic [BW-1:0] s1_br;
  logic [DW-1:0] s1_re, s1_im;
  logic [FW-1:0] s1_fill;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) s1_v <= 1'b0;
    else          s1_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_br   <= br_q;
      s1_re   <= in_re;
      s1_im   <= in_im;
      s1_fill <= fill_q;
    end
  end

  logic [HW-1:0]        hist_rd, hist_wr;
  logic [NTAP*CW-1:0]   coef_rd;
  logic [NTAP*DW-1:0]   tap_re, tap_im;
  logic                 coef_wr_en;

  assign coef_wr_en = coef_we & ~in_valid;

  pfb_coef_bank #(.NBR(NBR), .NTAP(NTAP), .CW(CW)) u_coef (
    .clk(clk), .wr_en(coef_wr_en), .wr_tap(coef_tap), .wr_addr(coef_branch),
    .wr_data(coef_val), .rd_en(in_valid), .rd_addr(br_q), .rd_data(coef_rd)
  );

  pfb_hist_ram #(.DEPTH(NBR), .WIDTH(HW)) u_hist (
    .clk(clk), .rd_en(in_valid), .rd_addr(br_q), .rd_data(hist_rd),
    .wr_en(s1_v), .wr_addr(s1_br), .wr_data(hist_wr)
  );

  // Tap assembly: older taps count only once enough passes have been made.
  assign tap_re[0 +: DW] = s1_re;
  assign tap_im[0 +: DW] = s1_im;

  for (genvar j = 1; j < NTAP; j++) begin : g_old
    logic live;
    assign live = (s1_fill >= FW'(j));
    assign tap_re[j*DW +: DW] = live ? hist_rd[(j-1)*SW + DW +: DW] : '0;
    assign tap_im[j*DW +: DW] = live ? hist_rd[(j-1)*SW +: DW]      : '0;
  end

  for (genvar i = 0; i < NTAP - 1; i++) begin : g_wb
    assign hist_wr[i*SW +: SW] = {tap_re[i*DW +: DW], tap_im[i*DW +: DW]};
  end

  logic [AW-1:0] sum_re, sum_im;

  pfb_mac #(.NTAP(NTAP), .DW(DW), .CW(CW), .AW(AW)) u_mac_re (
    .x_flat(tap_re), .c_flat(coef_rd), .sum(sum_re)
  );
  pfb_mac #(.NTAP(NTAP), .DW(DW), .CW(CW), .AW(AW)) u_mac_im (
    .x_flat(tap_im), .c_flat(coef_rd), .sum(sum_im)
  );

  // Stage 2: output register.
  logic          ov_q;
  logic [AW-1:0] ore_q, oim_q;
  logic [BW-1:0] obr_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ov_q  <= 1'b0;
      ore_q <= '0;
      oim_q <= '0;
      obr_q <= '0;
    end else begin
      ov_q <= s1_v;
      if (s1_v) begin
        ore_q <= sum_re;
        oim_q <= sum_im;
        obr_q <= s1_br;
      end
    end
  end

  assign out_valid  = ov_q;
  assign out_re     = ore_q;
  assign out_im     = oim_q;
  assign out_branch = obr_q;
endmodule

// File: rtl/pfb_chk.sv
module pfb_chk #(
  parameter int NBR  = 1024,
  parameter int NTAP = 5,
  parameter int DW   = 4,
  parameter int CW   = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_q_n,
  input  logic                                   in_valid,
  input  logic                                   out_valid,
  input  logic signed [DW+CW+$clog2(NTAP)-1:0]   out_re,
  input  logic signed [DW+CW+$clog2(NTAP)-1:0]   out_im,
  input  logic [$clog2(NBR)-1:0]                 out_branch
);
  localparam int BW  = $clog2(NBR);
  localparam int LIM = NTAP * (1 << (DW - 1)) * (1 << (CW - 1));

  logic [1:0]    age_q;
  logic          seen_q;
  logic [BW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      age_q  <= '0;
      seen_q <= 1'b0;
      last_q <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (out_valid) begin
        seen_q <= 1'b1;
        last_q <= out_branch;
      end
    end
  end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (age_q < 2'd2) |-> !out_valid);

  // R5
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (age_q == 2'd3) |-> (out_valid == $past(in_valid, 2)));

  // R2
  branch_rotation_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && seen_q) |-> (out_branch == BW'(last_q + 1'b1)));

  // R6
  re_bound_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> ((out_re <= LIM) && (out_re >= -LIM)));

  // R6
  im_bound_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> ((out_im <= LIM) && (out_im >= -LIM)));
endmodule

bind pfb_channelizer_front pfb_chk #(.NBR(NBR), .NTAP(NTAP), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_re(out_re), .out_im(out_im), .out_branch(out_branch)
);

// File: tb/sim_pfb_channelizer_front.sv
module sim_pfb_channelizer_front;
  localparam int NBR  = 1024;
  localparam int NTAP = 5;
  localparam int DROP_BR = 1000;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, coef_we;
  logic [3:0] in_re, in_im;
  logic [2:0] coef_tap;
  logic [9:0] coef_branch;
  logic [7:0] coef_val;
  logic out_valid;
  logic signed [14:0] out_re, out_im;
  logic [9:0] out_branch;

  always #4 clk = ~clk;

  pfb_channelizer_front u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .coef_we(coef_we), .coef_tap(coef_tap), .coef_branch(coef_branch),
    .coef_val(coef_val), .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
    .out_branch(out_branch)
  );

  typedef struct { int re; int im; int br; int tag; } exp_t;
  exp_t q[$];

  int coef_m [NTAP][NBR];
  int hre [NBR][NTAP];
  int him [NBR][NTAP];
  int sample_cnt = 0;
  int phase_tag = 3;
  bit dropped = 0;
  bit mon_en = 0;
  bit done = 0;
  int total = 0;
  int bad = 0;
  bit vh0 = 0, vh1 = 0;

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic void push_exp(int re, int im);
    int b;
    int w;
    int sr;
    int si;
    exp_t e;
    b = sample_cnt % NBR;
    w = sample_cnt / NBR;
    for (int j = NTAP - 1; j > 0; j--) begin
      hre[b][j] = hre[b][j-1];
      him[b][j] = him[b][j-1];
    end
    hre[b][0] = re;
    him[b][0] = im;
    sr = 0;
    si = 0;
    for (int j = 0; j < NTAP; j++) begin
      sr += coef_m[j][b] * hre[b][j];
      si += coef_m[j][b] * him[b][j];
    end
    e.re = sr;
    e.im = si;
    e.br = b;
    if (b == DROP_BR && dropped) e.tag = 8;
    else if (b == 0 && w >= NTAP - 1) e.tag = 6;
    else if (w < NTAP - 1) e.tag = 4;
    else e.tag = phase_tag;
    q.push_back(e);
    sample_cnt++;
  endfunction

  task automatic drive_sample(int re, int im, bit wl, int wv);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_re = re[3:0];
    in_im = im[3:0];
    coef_we = wl;
    coef_tap = 3'd0;
    coef_branch = 10'(DROP_BR);
    coef_val = wv[7:0];
    push_exp(re, im);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      coef_we = 1'b0;
    end
  endtask

  task automatic load_coef(int t, int b, int v);
    @(posedge clk); #1;
    in_valid = 1'b0;
    coef_we = 1'b1;
    coef_tap = 3'(t);
    coef_branch = 10'(b);
    coef_val = v[7:0];
    coef_m[t][b] = v;
  endtask

  task automatic load_all();
    for (int t = 0; t < NTAP; t++) begin
      for (int b = 0; b < NBR; b++) begin
        int v;
        if (b == 0) v = -128;
        else if (b == NBR - 1) v = 127;
        else v = int'($urandom % 256) - 128;
        load_coef(t, b, v);
      end
    end
    idle(1);
  endtask

  task automatic stream(int n, int drop_at);
    for (int i = 0; i < n; i++) begin
      int b;
      int re;
      int im;
      b = sample_cnt % NBR;
      if (b == 0) begin re = -8; im = -8; end
      else if (b == NBR - 1) begin re = 7; im = -8; end
      else begin
        re = int'($urandom % 16) - 8;
        im = int'($urandom % 16) - 8;
      end
      if (sample_cnt == drop_at) begin
        // R8: write attempt while the stream is active, model unchanged
        drive_sample(re, im, 1'b1, -coef_m[0][DROP_BR] - 1);
        dropped = 1;
      end else begin
        drive_sample(re, im, 1'b0, 0);
      end
      if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
    end
    idle(1);
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      // R5: valid two cycles after input valid
      check(out_valid == vh1, "R5 latency", int'(out_valid), int'(vh1));
      vh1 = vh0;
      vh0 = in_valid;
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R5 unexpected output", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(int'(out_branch) == e.br, "R2 branch", int'(out_branch), e.br);
          check(int'(out_re) == e.re, $sformatf("R%0d real", e.tag), int'(out_re), e.re);
          check(int'(out_im) == e.im, $sformatf("R%0d imag", e.tag), int'(out_im), e.im);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd4242));
    rst_n = 1'b0;
    in_valid = 1'b0;
    coef_we = 1'b0;
    in_re = '0;
    in_im = '0;
    coef_tap = '0;
    coef_branch = '0;
    coef_val = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    check(out_re == 0 && out_im == 0, "R1 data in reset", int'(out_re), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    check(out_re == 0 && out_im == 0, "R1 data after reset", int'(out_im), 0);
    mon_en = 1;

    // R7: initial coefficient set, loaded while idle
    load_all();
    // R3 R4 R6 R8: first pass includes fill and the dropped write
    phase_tag = 3;
    stream(6 * NBR, 5200);
    idle(4);
    dropped = 0;

    // R7: reload all coefficients and keep streaming with existing history
    load_all();
    phase_tag = 7;
    stream(2 * NBR, -1);

    // R9: long idle gap, history and rotation must survive
    idle(60);
    phase_tag = 9;
    stream(NBR + 80, -1);
    idle(8);
    check(q.size() == 0, "R5 all outputs delivered", q.size(), 0);
    finish_run();
  end
endmodule